// File: doc/BRIEF.md
# Trace Message Packetizer

The block gathers trace events from several on-chip sources and turns each event into one serial message on a narrow output port. The port has four data pins and a two-bit marker. A message has five packets. First comes a 6-bit transfer code, split over two beats. Next is a 4-bit source number. Then comes a variable-length instruction-count packet, and last a variable-length target-address packet. Every packet is sent low nibble first. A variable packet has its leading zero bits removed, and its last nibble is padded with zeros up to the port width.

Address packets are compressed against each source's own history. A normal message sends the XOR of the new address with the last address that source sent, with the leading zeros removed. A sync message sends the whole address and restarts the history. The first message a source sends after reset is always a sync message.

Each source has a one-entry holding register behind a valid/ready handshake. A round-robin arbiter picks which holding register goes next. A message is never interleaved with another one. When another message is waiting, it follows the previous one with no idle cycle between them.

Top module: `trc_msg_packetizer`

## Requirements
- R1: The beats of a message come in this order: transfer code bits [3:0]; transfer code bits [5:4] on data[1:0] with data[3:2]=0; the 4-bit source number; the count packet; the address packet. Within each packet the least significant nibble goes first.
- R2: Marker codes: 00 means idle with data 0000; 10 is an ordinary beat; 01 is the last beat of the count packet; 11 is the last beat of the message, which is the last address beat.
- R3: A variable packet is sent in ceil(b/4) beats, where b is the index of its highest set bit plus one. A value of zero counts as b=1 and is sent as one 0000 beat. Bits above b are sent as zeros.
- R4: A normal message uses transfer code 0x04. Its address packet is the new address XOR the last address sent by the same source, trimmed as in R3. An unchanged address is sent as one 0000 beat.
- R5: A sync message uses transfer code 0x09 and carries all ADDR_W/4 nibbles of the address, untrimmed. Every message, sync or normal, makes its address the new reference for its source.
- R6: The first message from each source after reset is a sync message, whatever the sync input says.
- R7: Each source is compressed only against its own history; messages from other sources do not change it.
- R8: ev_ready_o[i] is high while source i's holding register is empty. It is low from the cycle after an event is accepted until that event is taken for sending.
- R9: The arbiter is round-robin. After reset the search starts at source 0. After a grant to source k, it starts at source k+1 and wraps around.
- R10: Messages are never interleaved. A message that is waiting starts on the cycle right after the previous message's last beat.
- R11: During and right after reset, every ev_ready_o bit is 1, aux_mseo_o is 00 and aux_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | N_SRC | Event valid, one bit per source |
| ev_ready_o | output | N_SRC | Holding register empty, one bit per source |
| ev_sync_i | input | N_SRC | Request a sync message |
| ev_icnt_i | input | N_SRC*ICNT_W | Instruction count for each source, packed with source 0 lowest |
| ev_addr_i | input | N_SRC*ADDR_W | Target address for each source, packed with source 0 lowest |
| aux_data_o | output | 4 | Output data nibble |
| aux_mseo_o | output | 2 | Marker for message start and end |

## Verification
The corner cases are an unchanged address and a zero count, which must each become a single zero beat; a design that drops the minimum length sends an empty packet and breaks the framing. A single changed bit near the top of the address must give a four-beat packet, and a trimming bug shows up there as lost or extra nibbles. Events from two sources are interleaved to catch a design that keeps one shared reference address, and the tests are rerun after a mid-run reset to prove that sync is forced again. Events arriving together from several sources expose fixed-priority arbitration through the order of the messages. The bench also checks for an idle cycle between messages that are already queued.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned TC_W  = 6;
  localparam int unsigned SRC_W = 4;

  typedef enum logic [1:0] {
    MS_IDLE    = 2'b00,
    MS_PKT_END = 2'b01,
    MS_BEAT    = 2'b10,
    MS_MSG_END = 2'b11
  } mseo_e;

  typedef enum logic [2:0] {
    PH_TC_LO,
    PH_TC_HI,
    PH_SRC,
    PH_CNT,
    PH_ADR
  } phase_e;

  // nibbles needed for a trimmed value, at least one
  function automatic int unsigned var_beats(input logic [63:0] v);
    int unsigned hi;
    hi = 1;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) hi = i + 1;
    end
    return (hi + NIB_W - 1) / NIB_W;
  endfunction
endpackage

// File: rtl/trc_src_slot.sv
module trc_src_slot
  import trc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned ICNT_W   = 8,
  parameter int unsigned ADDR_NIB = 4,
  parameter int unsigned BW       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              sync_i,
  input  logic [ICNT_W-1:0] icnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              take_i,
  output logic              full_o,
  output logic              sync_o,
  output logic [ICNT_W-1:0] icnt_o,
  output logic [ADDR_W-1:0] pay_o,
  output logic [BW-1:0]     pay_beats_o
);
  logic              full_q, sync_q, seen_q;
  logic [ICNT_W-1:0] icnt_q;
  logic [ADDR_W-1:0] addr_q, ref_q;

  assign ready_o = ~full_q;
  assign full_o  = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      sync_q <= 1'b0;
      seen_q <= 1'b0;
      icnt_q <= '0;
      addr_q <= '0;
      ref_q  <= '0;
    end else begin
      if (valid_i && !full_q) begin
        full_q <= 1'b1;
        sync_q <= sync_i;
        icnt_q <= icnt_i;
        addr_q <= addr_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
      if (take_i) begin
        ref_q  <= addr_q;
        seen_q <= 1'b1;
      end
    end
  end

  // first message after reset is always sync
  assign sync_o = sync_q | ~seen_q;
  assign icnt_o = icnt_q;
  assign pay_o  = sync_o ? addr_q : (addr_q ^ ref_q);
  assign pay_beats_o = sync_o ? BW'(ADDR_NIB) : BW'(var_beats(64'(pay_o)));
endmodule

// File: rtl/trc_rr_arb.sv
module trc_rr_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          advance_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] gidx_o
);
  logic [IW-1:0] ptr_q;
  logic          found;
  int unsigned   idx;

  always_comb begin
    grant_o = '0;
    gidx_o  = '0;
    found   = 1'b0;
    idx     = 0;
    for (int k = 1; k <= int'(N); k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && req_i[idx]) begin
        found        = 1'b1;
        grant_o[idx] = 1'b1;
        gidx_o       = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= IW'(N - 1);
    else if (advance_i && found) ptr_q <= gidx_o;
  end
endmodule

// File: rtl/trc_serializer.sv
module trc_serializer
  import trc_pkg::*;
#(
  parameter int unsigned      ADDR_W  = 16,
  parameter int unsigned      ICNT_W  = 8,
  parameter int unsigned      BW      = 3,
  parameter logic [TC_W-1:0]  SYNC_TC = 6'h09,
  parameter logic [TC_W-1:0]  BR_TC   = 6'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sync_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [ICNT_W-1:0] icnt_i,
  input  logic [ADDR_W-1:0] pay_i,
  input  logic [BW-1:0]     pay_beats_i,
  output logic              free_o,
  output logic [NIB_W-1:0]  data_o,
  output logic [1:0]        mseo_o
);
  localparam int unsigned CSW = ((ICNT_W + NIB_W - 1) / NIB_W) * NIB_W;
  localparam int unsigned ASW = ((ADDR_W + NIB_W - 1) / NIB_W) * NIB_W;

  logic             active_q;
  phase_e           phase_q;
  logic [TC_W-1:0]  tc_q;
  logic [SRC_W-1:0] src_q;
  logic [CSW-1:0]   cnt_sh;
  logic [ASW-1:0]   adr_sh;
  logic [BW-1:0]    cnt_left, adr_left;
  logic             last;

  assign last   = active_q && (phase_q == PH_ADR) && (adr_left == BW'(1));
  assign free_o = ~active_q | last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= PH_TC_LO;
      tc_q     <= '0;
      src_q    <= '0;
      cnt_sh   <= '0;
      adr_sh   <= '0;
      cnt_left <= '0;
      adr_left <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      phase_q  <= PH_TC_LO;
      tc_q     <= sync_i ? SYNC_TC : BR_TC;
      src_q    <= src_i;
      cnt_sh   <= CSW'(icnt_i);
      cnt_left <= BW'(var_beats(64'(icnt_i)));
      adr_sh   <= ASW'(pay_i);
      adr_left <= pay_beats_i;
    end else if (active_q) begin
      unique case (phase_q)
        PH_TC_LO: phase_q <= PH_TC_HI;
        PH_TC_HI: phase_q <= PH_SRC;
        PH_SRC:   phase_q <= PH_CNT;
        PH_CNT: begin
          cnt_sh   <= cnt_sh >> NIB_W;
          cnt_left <= cnt_left - BW'(1);
          if (cnt_left == BW'(1)) phase_q <= PH_ADR;
        end
        PH_ADR: begin
          adr_sh   <= adr_sh >> NIB_W;
          adr_left <= adr_left - BW'(1);
          if (adr_left == BW'(1)) active_q <= 1'b0;
        end
        default: active_q <= 1'b0;
      endcase
    end
  end

  always_comb begin
    data_o = '0;
    mseo_o = MS_IDLE;
    if (active_q) begin
      unique case (phase_q)
        PH_TC_LO: begin data_o = tc_q[3:0];         mseo_o = MS_BEAT; end
        PH_TC_HI: begin data_o = {2'b00, tc_q[5:4]}; mseo_o = MS_BEAT; end
        PH_SRC:   begin data_o = src_q;             mseo_o = MS_BEAT; end
        PH_CNT: begin
          data_o = cnt_sh[NIB_W-1:0];
          mseo_o = (cnt_left == BW'(1)) ? MS_PKT_END : MS_BEAT;
        end
        PH_ADR: begin
          data_o = adr_sh[NIB_W-1:0];
          mseo_o = (adr_left == BW'(1)) ? MS_MSG_END : MS_BEAT;
        end
        default: begin data_o = '0; mseo_o = MS_IDLE; end
      endcase
    end
  end
endmodule

// File: rtl/trc_msg_packetizer.sv
module trc_msg_packetizer
  import trc_pkg::*;
#(
  parameter int unsigned     N_SRC   = 4,
  parameter int unsigned     ADDR_W  = 16,
  parameter int unsigned     ICNT_W  = 8,
  parameter logic [5:0]      SYNC_TC = 6'h09,
  parameter logic [5:0]      BR_TC   = 6'h04
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_SRC-1:0]          ev_valid_i,
  output logic [N_SRC-1:0]          ev_ready_o,
  input  logic [N_SRC-1:0]          ev_sync_i,
  input  logic [N_SRC*ICNT_W-1:0]   ev_icnt_i,
  input  logic [N_SRC*ADDR_W-1:0]   ev_addr_i,
  output logic [3:0]                aux_data_o,
  output logic [1:0]                aux_mseo_o
);
  localparam int unsigned IW       = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned ADDR_NIB = (ADDR_W + NIB_W - 1) / NIB_W;
  localparam int unsigned ICNT_NIB = (ICNT_W + NIB_W - 1) / NIB_W;
  localparam int unsigned MAX_NIB  = (ADDR_NIB > ICNT_NIB) ? ADDR_NIB : ICNT_NIB;
  localparam int unsigned BW       = $clog2(MAX_NIB + 1);

  logic [N_SRC-1:0]  slot_full, slot_sync, grant, take;
  logic [ICNT_W-1:0] slot_icnt  [N_SRC];
  logic [ADDR_W-1:0] slot_pay   [N_SRC];
  logic [BW-1:0]     slot_beats [N_SRC];
  logic [IW-1:0]     gidx;
  logic              ser_free, load;

  assign load = ser_free & (|slot_full);
  assign take = grant & {N_SRC{load}};

  for (genvar i = 0; i < N_SRC; i++) begin : g_slot
    trc_src_slot #(
      .ADDR_W(ADDR_W), .ICNT_W(ICNT_W), .ADDR_NIB(ADDR_NIB), .BW(BW)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .valid_i     (ev_valid_i[i]),
      .ready_o     (ev_ready_o[i]),
      .sync_i      (ev_sync_i[i]),
      .icnt_i      (ev_icnt_i[i*ICNT_W +: ICNT_W]),
      .addr_i      (ev_addr_i[i*ADDR_W +: ADDR_W]),
      .take_i      (take[i]),
      .full_o      (slot_full[i]),
      .sync_o      (slot_sync[i]),
      .icnt_o      (slot_icnt[i]),
      .pay_o       (slot_pay[i]),
      .pay_beats_o (slot_beats[i])
    );
  end

  trc_rr_arb #(.N(N_SRC), .IW(IW)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (slot_full),
    .advance_i (load),
    .grant_o   (grant),
    .gidx_o    (gidx)
  );

  trc_serializer #(
    .ADDR_W(ADDR_W), .ICNT_W(ICNT_W), .BW(BW), .SYNC_TC(SYNC_TC), .BR_TC(BR_TC)
  ) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .sync_i      (slot_sync[gidx]),
    .src_i       (SRC_W'(gidx)),
    .icnt_i      (slot_icnt[gidx]),
    .pay_i       (slot_pay[gidx]),
    .pay_beats_i (slot_beats[gidx]),
    .free_o      (ser_free),
    .data_o      (aux_data_o),
    .mseo_o      (aux_mseo_o)
  );
endmodule

// File: rtl/trc_msg_packetizer_chk.sv
module trc_msg_packetizer_chk #(
  parameter int unsigned N_SRC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] ev_valid_i,
  input logic [N_SRC-1:0] ev_ready_o,
  input logic [3:0]       aux_data_o,
  input logic [1:0]       aux_mseo_o,
  input logic [N_SRC-1:0] grant_i
);
  logic [7:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else if (aux_mseo_o == 2'b11) pos_q <= '0;
    else if (aux_mseo_o != 2'b00 && pos_q != 8'hff) pos_q <= pos_q + 8'd1;
  end

  a_r1_header_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q < 8'd3 && aux_mseo_o != 2'b00) |-> aux_mseo_o == 2'b10);

  a_r1_tc_hi_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == 8'd1 && aux_mseo_o != 2'b00) |-> aux_data_o[3:2] == 2'b00);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_mseo_o == 2'b00 |-> aux_data_o == 4'h0);

  a_r10_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_mseo_o == 2'b10 || aux_mseo_o == 2'b01) |=> aux_mseo_o != 2'b00);

  a_r2_cnt_then_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_mseo_o == 2'b01 |=> (aux_mseo_o == 2'b10 || aux_mseo_o == 2'b11));

  a_r8_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i & ev_ready_o) != '0 |=> (ev_ready_o & $past(ev_valid_i & ev_ready_o)) == '0);

  a_r9_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));
endmodule

bind trc_msg_packetizer trc_msg_packetizer_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ev_valid_i (ev_valid_i),
  .ev_ready_o (ev_ready_o),
  .aux_data_o (aux_data_o),
  .aux_mseo_o (aux_mseo_o),
  .grant_i    (grant)
);

// File: tb/trc_msg_packetizer_tb.sv
module trc_msg_packetizer_tb;
  localparam int NS = 4;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] valid = '0;
  logic [NS-1:0] ready;
  logic [NS-1:0] sync_v = '0;
  logic [NS*CW-1:0] icnt_v = '0;
  logic [NS*AW-1:0] addr_v = '0;
  logic [3:0]    data;
  logic [1:0]    mseo;

  always #5 clk = ~clk;

  trc_msg_packetizer #(.N_SRC(NS), .ADDR_W(AW), .ICNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(valid), .ev_ready_o(ready),
    .ev_sync_i(sync_v), .ev_icnt_i(icnt_v), .ev_addr_i(addr_v),
    .aux_data_o(data), .aux_mseo_o(mseo)
  );

  // {src[3:0], sync, 3'b0, icnt[7:0], addr[15:0]}
  localparam logic [31:0] VEC [12] = '{
    {4'd0, 1'b0, 3'b0, 8'h05, 16'h1234},
    {4'd0, 1'b0, 3'b0, 8'h00, 16'h1234},
    {4'd0, 1'b0, 3'b0, 8'hff, 16'h1235},
    {4'd1, 1'b0, 3'b0, 8'h10, 16'habcd},
    {4'd0, 1'b0, 3'b0, 8'h01, 16'h1335},
    {4'd1, 1'b0, 3'b0, 8'h80, 16'h2bcd},
    {4'd1, 1'b1, 3'b0, 8'h03, 16'h2bce},
    {4'd1, 1'b0, 3'b0, 8'h07, 16'h2bcf},
    {4'd2, 1'b1, 3'b0, 8'h00, 16'h0000},
    {4'd3, 1'b0, 3'b0, 8'h10, 16'hffff},
    {4'd3, 1'b0, 3'b0, 8'h02, 16'h0fff},
    {4'd0, 1'b0, 3'b0, 8'h09, 16'h1334}
  };

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rx_n = 0, msg_done = 0;
  logic [3:0] rx_nib [1024];
  logic [1:0] rx_ms  [1024];
  int         rx_cyc [1024];
  logic [3:0] exp_nib [64];
  logic [1:0] exp_ms  [64];
  int         exp_n = 0;
  logic [AW-1:0] m_ref [NS];
  logic          m_seen [NS];

  always @(negedge clk) begin
    cyc++;
    if (rst_n && mseo != 2'b00 && rx_n < 1024) begin
      rx_nib[rx_n] = data;
      rx_ms[rx_n]  = mseo;
      rx_cyc[rx_n] = cyc;
      rx_n++;
      if (mseo == 2'b11) msg_done++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic int vbeats(input logic [15:0] v);
    int n = 1;
    while (n < 4 && (v >> (4 * n)) != 0) n++;
    return n;
  endfunction

  task automatic push(input logic [3:0] nb, input logic [1:0] ms);
    exp_nib[exp_n] = nb;
    exp_ms[exp_n]  = ms;
    exp_n++;
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin m_ref[s] = '0; m_seen[s] = 1'b0; end
  endtask

  // expected beats from R1-style framing rules
  task automatic build_exp(input int s, input bit sy, input logic [7:0] ic, input logic [15:0] ad);
    bit eff = sy || !m_seen[s];
    logic [5:0] tc = eff ? 6'h09 : 6'h04;
    logic [15:0] pay = eff ? ad : (ad ^ m_ref[s]);
    int n;
    push(tc[3:0], 2'b10);
    push({2'b00, tc[5:4]}, 2'b10);
    push(4'(s), 2'b10);
    n = vbeats(16'(ic));
    for (int k = 0; k < n; k++) push(4'(ic >> (4 * k)), (k == n - 1) ? 2'b01 : 2'b10);
    n = eff ? AW / 4 : vbeats(pay);
    for (int k = 0; k < n; k++) push(4'(pay >> (4 * k)), (k == n - 1) ? 2'b11 : 2'b10);
    m_ref[s]  = ad;
    m_seen[s] = 1'b1;
  endtask

  task automatic compare(input int start, input string req);
    int bad = -1;
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && (rx_nib[start+i] !== exp_nib[i] || rx_ms[start+i] !== exp_ms[i])) bad = i;
    if (rx_n - start != exp_n) check(1'b0, req, "beat count", rx_n - start, exp_n);
    else if (bad >= 0) check(1'b0, req, $sformatf("beat %0d {mseo,data}", bad),
                             {rx_ms[start+bad], rx_nib[start+bad]}, {exp_ms[bad], exp_nib[bad]});
    else check(1'b1, req, "message", 0, 0);
  endtask

  task automatic stage(input int s, input bit sy, input logic [7:0] ic, input logic [15:0] ad);
    sync_v[s] = sy;
    icnt_v[s*CW +: CW] = ic;
    addr_v[s*AW +: AW] = ad;
  endtask

  task automatic drive_set(input logic [NS-1:0] mask);
    logic [NS-1:0] pend = mask, r;
    valid = mask;
    while (pend != 0) begin
      r = ready & pend;
      @(posedge clk);
      @(negedge clk);
      pend  = pend & ~r;
      valid = pend;
    end
  endtask

  task automatic wait_msgs(input int k);
    int tgt = msg_done + k;
    while (msg_done < tgt) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: got %0d expected %0d messages done", msg_done, -1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int start, e1;
    model_reset();
    repeat (3) @(negedge clk);
    check(ready === 4'hf, "R11", "ready in reset", ready, 4'hf);
    rst_n = 1'b1;
    @(negedge clk);
    check(mseo === 2'b00, "R11", "mseo after reset", mseo, 0);
    check(data === 4'h0, "R11", "data after reset", data, 0);

    // table: R1-R7 over varied counts and addresses
    for (int v = 0; v < 12; v++) begin
      int s = int'(VEC[v][31:28]);
      exp_n = 0;
      build_exp(s, VEC[v][27], VEC[v][23:16], VEC[v][15:0]);
      start = rx_n;
      stage(s, VEC[v][27], VEC[v][23:16], VEC[v][15:0]);
      drive_set(NS'(1) << s);
      wait_msgs(1);
      compare(start, $sformatf("R3/R4/R5/R6/R7 vec%0d", v));
    end

    // R6 again after reset, then R9 order with R8 back-pressure
    do_reset();
    exp_n = 0;
    build_exp(0, 1'b0, 8'h21, 16'h4000);
    start = rx_n;
    stage(0, 1'b0, 8'h21, 16'h4000);
    drive_set(4'b0001);
    wait_msgs(1);
    compare(start, "R6 after reset");

    exp_n = 0;
    build_exp(1, 1'b0, 8'h02, 16'h0011);
    build_exp(0, 1'b0, 8'h03, 16'h4001);
    start = rx_n;
    stage(0, 1'b0, 8'h03, 16'h4001);
    stage(1, 1'b0, 8'h02, 16'h0011);
    drive_set(4'b0011);
    check(ready[1:0] === 2'b00, "R8", "ready while held", ready[1:0], 0);
    wait_msgs(2);
    compare(start, "R9 rr order src1 then src0");
    e1 = start;
    while (e1 < rx_n - 1 && rx_ms[e1] != 2'b11) e1++;
    check(rx_cyc[e1+1] == rx_cyc[e1] + 1, "R10", "cycle of next message start",
          rx_cyc[e1+1], rx_cyc[e1] + 1);

    exp_n = 0;
    build_exp(1, 1'b0, 8'h00, 16'h0013);
    build_exp(2, 1'b0, 8'h44, 16'h8000);
    build_exp(3, 1'b1, 8'h05, 16'h0007);
    start = rx_n;
    stage(1, 1'b0, 8'h00, 16'h0013);
    stage(2, 1'b0, 8'h44, 16'h8000);
    stage(3, 1'b1, 8'h05, 16'h0007);
    drive_set(4'b1110);
    wait_msgs(3);
    compare(start, "R9/R10 three sources whole and in order");
    check(ready === 4'hf, "R8", "ready after drain", ready, 4'hf);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule